// File: doc/BRIEF.md
# Mapped Processor Register File

This block is a 32-bit register file that a processor core addresses with an 8-bit register number. It has one synchronous write port and one combinational read port. The address space is decoded into regions of different kinds. Some regions are real storage: the general registers, two special-purpose registers that neighbouring units use, and a bank of auxiliary registers. Some are holes with no storage. Four locations are hardwired constants.

A control module turns the write and read addresses into a small bundle of strobes: a store-write enable with a flat storage index, and a read selection that picks storage, a constant, or zero. The datapath module holds the storage and builds the read value from those strobes. The two special registers are modelled only as storage. Whatever logic would consume or fill them sits outside this block.

Top module: `mapped_regfile`

## Requirements
- R1: Addresses 0 to 127 are general registers. A value written there at a rising edge is returned on rdData for that address from the next cycle onward.
- R2: Addresses 128 and 129 hold no storage. A write there changes no location, and a read returns zero.
- R3: Addresses 130 and 131 are special registers. Each one stores and returns any 32-bit value, including all-ones and single-bit patterns.
- R4: Addresses 132, 133, 134 and 135 always read 0, 1, 2 and 3. A write there changes no location and does not alter the constants.
- R5: Addresses 136 to 159 are auxiliary registers that can be written and read back like the general registers.
- R6: Addresses 160 to 255 are unimplemented. A read returns zero, and a write changes no location.
- R7: A write changes only the addressed location. After every storage location is filled with a walking-one pattern, or with a walking-zero pattern, each location reads back its own value.
- R8: Reads are combinational. A read of the address being written in the same cycle returns the value held before that edge.
- R9: A synchronous reset (rst high at a rising edge) clears every storage location to zero. The constants keep their values during and after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset of all storage |
| wrEn | input | 1 | Write request for this cycle |
| wrAddr | input | 8 | Register number to write |
| wrData | input | 32 | Value to write |
| rdAddr | input | 8 | Register number to read |
| rdData | output | 32 | Read value, combinational from rdAddr and current storage |

## Verification
A write takes effect at the rising edge that samples wrEn, so its value can be read back from the next cycle. The read path has no register, so rdData follows rdAddr within the same cycle. The bench therefore drives inputs on the falling edge and samples rdData shortly after the change, without waiting for a clock. Readback checks come one falling edge after the write, and one edge covers the write. The same-cycle check samples before the write's edge and again after it, to show first the old value and then the new one.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

  localparam int IDX_W = 8;

  typedef struct packed {
    logic             wrStore;
    logic [IDX_W-1:0] wrIdx;
    logic             rdStore;
    logic [IDX_W-1:0] rdIdx;
    logic             rdConst;
    logic [IDX_W-1:0] constVal;
  } rf_strobe_t;

endpackage

// File: rtl/regfile_ctrl.sv
module regfile_ctrl
  import regfile_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int GEN_N      = 128,
  parameter int SPEC_BASE  = 130,
  parameter int SPEC_N     = 2,
  parameter int CONST_BASE = 132,
  parameter int CONST_N    = 4,
  parameter int AUX_BASE   = 136,
  parameter int AUX_N      = 24
) (
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output rf_strobe_t        strobes
);

  localparam int SPEC_SLOT = GEN_N;
  localparam int AUX_SLOT  = GEN_N + SPEC_N;

  function automatic void mapAddr(
    input  logic [ADDR_W-1:0] addr,
    output logic              isStore,
    output logic [IDX_W-1:0]  idx,
    output logic              isConst,
    output logic [IDX_W-1:0]  cval
  );
    int a;
    a       = int'(addr);
    isStore = 1'b0;
    isConst = 1'b0;
    idx     = '0;
    cval    = '0;
    if (a < GEN_N) begin
      isStore = 1'b1;
      idx     = IDX_W'(a);
    end else if (a >= SPEC_BASE && a < SPEC_BASE + SPEC_N) begin
      isStore = 1'b1;
      idx     = IDX_W'(a - SPEC_BASE + SPEC_SLOT);
    end else if (a >= CONST_BASE && a < CONST_BASE + CONST_N) begin
      isConst = 1'b1;
      cval    = IDX_W'(a - CONST_BASE);
    end else if (a >= AUX_BASE && a < AUX_BASE + AUX_N) begin
      isStore = 1'b1;
      idx     = IDX_W'(a - AUX_BASE + AUX_SLOT);
    end
  endfunction

  logic             wrHit;
  logic [IDX_W-1:0] wrSlot;
  logic             wrConstUnused;
  logic [IDX_W-1:0] wrCvalUnused;

  always_comb begin
    mapAddr(wrAddr, wrHit, wrSlot, wrConstUnused, wrCvalUnused);
    strobes.wrStore = wrEn & wrHit;
    strobes.wrIdx   = wrSlot;
    mapAddr(rdAddr, strobes.rdStore, strobes.rdIdx, strobes.rdConst, strobes.constVal);
  end

  always_comb begin
    assert (!(strobes.rdStore && strobes.rdConst)) // R4
      else $error("AST_READ_SELECT_EXCLUSIVE");
  end

endmodule

// File: rtl/regfile_store.sv
module regfile_store
  import regfile_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int STORE_N = 154
) (
  input  logic              clk,
  input  logic              rst,
  input  rf_strobe_t        strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [STORE_N-1:0][DATA_W-1:0] mem;

  for (genvar i = 0; i < STORE_N; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        mem[i] <= '0;
      end else if (strobes.wrStore && strobes.wrIdx == IDX_W'(i)) begin
        mem[i] <= wrData;
      end
    end
  end

  always_comb begin
    if (strobes.rdStore) begin
      rdData = mem[strobes.rdIdx];
    end else if (strobes.rdConst) begin
      rdData = DATA_W'(strobes.constVal);
    end else begin
      rdData = '0;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> mem == '0) // R9
    else $error("AST_RESET_CLEARS");

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !strobes.wrStore |=> $stable(mem)) // R6
    else $error("AST_IDLE_HOLDS");

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (rst)
    ($past(strobes.wrStore) && !$past(rst) && strobes.rdStore &&
     strobes.rdIdx == $past(strobes.wrIdx)) |-> rdData == $past(wrData)) // R1
    else $error("AST_WRITE_READBACK");

endmodule

// File: rtl/mapped_regfile.sv
module mapped_regfile
  import regfile_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int GEN_N      = 128,
  parameter int SPEC_BASE  = 130,
  parameter int SPEC_N     = 2,
  parameter int CONST_BASE = 132,
  parameter int CONST_N    = 4,
  parameter int AUX_BASE   = 136,
  parameter int AUX_N      = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  localparam int STORE_N  = GEN_N + SPEC_N + AUX_N;
  localparam int MAP_END  = AUX_BASE + AUX_N;

  rf_strobe_t strobes;

  regfile_ctrl #(
    .ADDR_W(ADDR_W), .GEN_N(GEN_N), .SPEC_BASE(SPEC_BASE), .SPEC_N(SPEC_N),
    .CONST_BASE(CONST_BASE), .CONST_N(CONST_N), .AUX_BASE(AUX_BASE), .AUX_N(AUX_N)
  ) i_ctrl (
    .wrAddr (wrAddr),
    .wrEn   (wrEn),
    .rdAddr (rdAddr),
    .strobes(strobes)
  );

  regfile_store #(
    .DATA_W(DATA_W), .STORE_N(STORE_N)
  ) i_store (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .wrData (wrData),
    .rdData (rdData)
  );

  AST_CONST_VALUE: assert property (@(posedge clk) disable iff (rst)
    (int'(rdAddr) >= CONST_BASE && int'(rdAddr) < CONST_BASE + CONST_N)
      |-> rdData == DATA_W'(int'(rdAddr) - CONST_BASE)) // R4
    else $error("AST_CONST_VALUE");

  AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (int'(rdAddr) >= GEN_N && int'(rdAddr) < SPEC_BASE) |-> rdData == '0) // R2
    else $error("AST_HOLE_ZERO");

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (int'(rdAddr) >= MAP_END) |-> rdData == '0) // R6
    else $error("AST_UNMAPPED_ZERO");

endmodule

// File: tb/test_mapped_regfile.sv
`timescale 1ns/1ps
module test_mapped_regfile;

  localparam real HALF = 2.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(HALF) clk = ~clk;

  mapped_regfile i_mapped_regfile (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  // vector: write address, write data, read address, expected, requirement
  typedef struct packed {
    logic [7:0]  wa;
    logic [31:0] wd;
    logic [7:0]  ra;
    logic [31:0] ex;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{8'd5,   32'hA5A5A5A5, 8'd5,   32'hA5A5A5A5, 4'd1}, // R1
    '{8'd127, 32'h0000FFFF, 8'd127, 32'h0000FFFF, 4'd1}, // R1
    '{8'd128, 32'hFFFFFFFF, 8'd128, 32'h00000000, 4'd2}, // R2
    '{8'd129, 32'h12345678, 8'd129, 32'h00000000, 4'd2}, // R2
    '{8'd130, 32'hDEADBEEF, 8'd130, 32'hDEADBEEF, 4'd3}, // R3
    '{8'd131, 32'h80000001, 8'd131, 32'h80000001, 4'd3}, // R3
    '{8'd132, 32'hFFFFFFFF, 8'd132, 32'h00000000, 4'd4}, // R4
    '{8'd133, 32'h00000007, 8'd133, 32'h00000001, 4'd4}, // R4
    '{8'd135, 32'h00000000, 8'd135, 32'h00000003, 4'd4}, // R4
    '{8'd136, 32'h0F0F0F0F, 8'd136, 32'h0F0F0F0F, 4'd5}, // R5
    '{8'd159, 32'hC3C3C3C3, 8'd159, 32'hC3C3C3C3, 4'd5}, // R5
    '{8'd200, 32'h0000FFFF, 8'd200, 32'h00000000, 4'd6}, // R6
    '{8'd255, 32'h00000001, 8'd255, 32'h00000000, 4'd6}, // R6
    '{8'd160, 32'h55555555, 8'd5,   32'hA5A5A5A5, 4'd7}  // R7
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readCheck(input string tag, input logic [7:0] a, input logic [31:0] exp);
    rdAddr = a;
    #0.5;
    check(tag, rdData, exp);
  endtask

  function automatic bit isStore(input int a);
    return (a < 128) || a == 130 || a == 131 || (a >= 136 && a < 160);
  endfunction

  function automatic logic [31:0] sweepValue(input int k, input bit inv);
    logic [31:0] v;
    v = 32'h1 << (k % 32);
    return inv ? ~v : v;
  endfunction

  task automatic sweep(input bit inv);
    int k;
    k = 0;
    for (int a = 0; a < 256; a++) begin
      if (isStore(a)) begin
        doWrite(8'(a), sweepValue(k, inv));
        k++;
      end else begin
        doWrite(8'(a), 32'hFFFFFFFF);
      end
    end
    k = 0;
    for (int a = 0; a < 256; a++) begin
      logic [31:0] exp;
      if (isStore(a)) begin
        exp = sweepValue(k, inv);
        k++;
      end else if (a >= 132 && a < 136) begin
        exp = 32'(a - 132);
      end else begin
        exp = '0;
      end
      readCheck(inv ? "R7 walking-zero" : "R7 walking-one", 8'(a), exp);
    end
  endtask

  initial begin
    #(HALF * 2 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // reset state: R9
    readCheck("R9 reset general", 8'd0, 32'h0);
    readCheck("R9 reset aux", 8'd159, 32'h0);
    readCheck("R9 constant at reset", 8'd134, 32'h2);

    for (int i = 0; i < NVEC; i++) begin
      doWrite(VECS[i].wa, VECS[i].wd);
      readCheck($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].ra, VECS[i].ex);
    end

    // R8: same-cycle read returns old value, then the new one
    doWrite(8'd10, 32'h11111111);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 8'd10; wrData = 32'h22222222; rdAddr = 8'd10;
    #0.5;
    check("R8 same-cycle old value", rdData, 32'h11111111);
    @(negedge clk);
    wrEn = 1'b0;
    #0.5;
    check("R8 new value after edge", rdData, 32'h22222222);

    sweep(1'b0);
    sweep(1'b1);

    // R9: reset mid-run clears storage, keeps constants
    doWrite(8'd130, 32'hCAFEF00D);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    readCheck("R9 reset clears special", 8'd130, 32'h0);
    readCheck("R9 reset clears general", 8'd10, 32'h0);
    readCheck("R9 reset clears aux", 8'd136, 32'h0);
    readCheck("R9 constant survives", 8'd135, 32'h3);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule